// File: doc/BRIEF.md
# Luminance Special-Effects Processor

This block sits in a video luminance path. It takes one 8-bit luma sample per clock, marked by a valid strobe. A start-of-line strobe and a start-of-frame strobe travel with the first sample of each line and of each frame. The block applies a programmable gain, adds a pedestal, and can then apply several picture effects: block mosaic, solarization by keeping only low-order bits, threshold slicing with selectable polarity, negative inversion, and a forced blank. Every arithmetic step saturates to the range 0..255. The output keeps a fixed latency of three clock cycles. The strobes and a sepia flag come out delayed by the same amount, so downstream chroma logic can act on the flag.

For the mosaic, each square block repeats its top-left sample. Across a line, the block holds the first sample it sees. A small line store keeps one value per block from the top line of each block row, and the following lines of that block row replay those values. The configuration inputs are expected to be static while a frame streams through. Each pipeline stage reads its own controls directly.

Top module: `luma_fx_top`

## Requirements
- R1: While reset is high and on the first cycle after it, out_vld, out_sol, out_sof, out_sepia and out_y are all 0.
- R2: The gain stage computes floor(sample × cfg_gain / 32) and doubles the result when cfg_gain_x2 is 1. A result above 255 becomes 255. A cfg_gain of 32 passes the sample unchanged.
- R3: cfg_ped is added to the gained value, and the sum saturates at 255.
- R4: With cfg_mos_en=1, the block width is N = 4, 8, 16 or 32 for cfg_mos_size 00, 01, 10, 11. Column numbering starts at 0 on the sample that carries in_sol. On the top line of a block row, every sample whose column is a multiple of N is passed on, and the next N-1 samples are replaced by it.
- R5: Line numbering starts at 0 on the line that carries in_sof and increases by 1 with each later in_sol. On a line whose number is not a multiple of N, each output equals the value produced at the same column on the most recent line whose number is a multiple of N.
- R6: With cfg_sol_en=1, the value is reduced to its 3 + cfg_sol_depth least significant bits, so cfg_sol_depth 00..11 keeps 3..6 bits.
- R7: With cfg_slc_en=1, the value becomes binary. Let hit mean the value is strictly greater than cfg_slc_level. With cfg_slc_pol=1 the output is 255 on a hit and 0 otherwise. With cfg_slc_pol=0 it is 0 on a hit and 255 otherwise.
- R8: With cfg_neg=1, the value v is replaced by 255 - v.
- R9: With cfg_clear=1, out_y is 0 for every valid sample, whatever the other controls are.
- R10: The stages run in this order: gain, pedestal, mosaic, solarize, slice, invert, clear. A disabled effect passes its input unchanged.
- R11: out_vld, out_sol, out_sof and out_sepia equal in_vld, in_sol, in_sof and cfg_sepia from three cycles earlier. out_y for a sample appears in that same cycle.
- R12: While in_vld is 0, in_y, in_sol and in_sof have no effect. No output becomes valid, and the column and line positions do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample valid |
| in_sol | input | 1 | First sample of a line |
| in_sof | input | 1 | First sample of a frame (sent together with in_sol) |
| in_y | input | 8 | Input luma sample |
| cfg_gain | input | 6 | Gain code, gain = code/32 |
| cfg_gain_x2 | input | 1 | Extra ×2 gain |
| cfg_ped | input | 8 | Pedestal added after gain |
| cfg_mos_en | input | 1 | Mosaic enable |
| cfg_mos_size | input | 2 | Mosaic block size code (4/8/16/32) |
| cfg_sol_en | input | 1 | Solarization enable |
| cfg_sol_depth | input | 2 | Low bits kept, 3 + code |
| cfg_slc_en | input | 1 | Slice enable |
| cfg_slc_pol | input | 1 | Slice polarity, 1 = positive |
| cfg_slc_level | input | 8 | Slice threshold |
| cfg_neg | input | 1 | Negative inversion |
| cfg_clear | input | 1 | Force output luma to 0 |
| cfg_sepia | input | 1 | Sepia flag, passed to the output |
| out_vld | output | 1 | Output sample valid |
| out_sol | output | 1 | Output first sample of a line |
| out_sof | output | 1 | Output first sample of a frame |
| out_y | output | 8 | Output luma |
| out_sepia | output | 1 | Delayed sepia flag |

## Verification
The input frames use a pattern that mixes column and line terms. Column 1 is forced to 255 and column 2 to 0, so saturation in the gain and pedestal stages shows up on every line, and a mosaic hold that starts in the wrong column changes the value seen. Each mosaic size runs on a 64×64 frame with idle gaps between lines. This separates a correct vertical replay from one that restarts every line or ignores the frame start. The gap cycles drive spurious line and frame strobes, which exposes positions that advance while no sample is valid. The solarize depths, both slice polarities, the threshold extremes 0 and 255, and a combined chain are each compared sample by sample against a behavioural model. This shows whether the stage order and the bit counts are correct.

// File: rtl/luma_fx_pkg.sv
package luma_fx_pkg;

    localparam int PIX_W        = 8;
    localparam int GAIN_W       = 6;
    localparam int GAIN_FRAC    = 5;
    localparam int WIDE_W       = PIX_W + 2;
    localparam int MOS_MIN_LOG2 = 2;
    localparam int SOL_BASE     = 3;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [WIDE_W-1:0] wide_t;

    localparam pix_t PIX_MAX = '1;

    typedef enum logic [1:0] {
        MOS_BLK4  = 2'b00,
        MOS_BLK8  = 2'b01,
        MOS_BLK16 = 2'b10,
        MOS_BLK32 = 2'b11
    } mos_size_e;

    // one pipeline beat: strobes travel with the sample
    typedef struct packed {
        logic vld;
        logic sol;
        logic sof;
        logic sepia;
        pix_t y;
    } beat_t;

    function automatic pix_t sat_pix(input wide_t v);
        return (v > wide_t'(PIX_MAX)) ? PIX_MAX : v[PIX_W-1:0];
    endfunction

    function automatic pix_t apply_gain(input pix_t y,
                                        input logic [GAIN_W-1:0] g,
                                        input logic x2);
        logic [PIX_W+GAIN_W-1:0] prod;
        wide_t scaled;
        prod   = y * g;
        scaled = wide_t'(prod >> GAIN_FRAC);
        if (x2) scaled = scaled << 1;
        return sat_pix(scaled);
    endfunction

    function automatic pix_t add_pedestal(input pix_t a, input pix_t b);
        wide_t s;
        s = wide_t'(a) + wide_t'(b);
        return sat_pix(s);
    endfunction

    function automatic pix_t solarize(input pix_t v, input logic [1:0] depth);
        wide_t m;
        m = (wide_t'(1) << (SOL_BASE + int'(depth))) - wide_t'(1);
        return v & pix_t'(m);
    endfunction

    function automatic pix_t slice_pix(input pix_t v, input pix_t level, input logic pol);
        logic hit;
        hit = (v > level);
        return (hit == pol) ? PIX_MAX : '0;
    endfunction

endpackage

// File: rtl/luma_gain_ped.sv
module luma_gain_ped
    import luma_fx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  beat_t                 in_b,
    input  logic [GAIN_W-1:0]     gain,
    input  logic                  gain_x2,
    input  pix_t                  ped,
    output beat_t                 out_b
);
    pix_t gained;
    pix_t lifted;

    always_comb begin
        gained = apply_gain(in_b.y, gain, gain_x2);
        lifted = add_pedestal(gained, ped);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_b <= '0;
        end else begin
            out_b <= '{vld: in_b.vld, sol: in_b.sol, sof: in_b.sof,
                       sepia: in_b.sepia, y: lifted};
        end
    end
endmodule

// File: rtl/luma_mosaic.sv
module luma_mosaic
    import luma_fx_pkg::*;
#(
    parameter int MAX_COLS = 1024,
    parameter int MAX_ROWS = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  beat_t      in_b,
    input  logic       en,
    input  mos_size_e  size,
    output beat_t      out_b
);
    localparam int COL_W  = $clog2(MAX_COLS);
    localparam int ROW_W  = $clog2(MAX_ROWS);
    localparam int SLOTS  = MAX_COLS >> MOS_MIN_LOG2;
    localparam int SLOT_W = $clog2(SLOTS);

    logic [COL_W-1:0]  col_q, cur_col, col_mask;
    logic [ROW_W-1:0]  row_q, cur_row, row_mask;
    logic [2:0]        blk_log2;
    logic [SLOT_W-1:0] slot;
    logic              blk_left, blk_top;
    pix_t              hold_q;
    pix_t              mos_y;
    pix_t              line_mem [SLOTS];

    // position of the current sample inside the frame
    always_comb begin
        cur_col  = in_b.sol ? '0 : col_q;
        if (in_b.sof)      cur_row = '0;
        else if (in_b.sol) cur_row = row_q + 1'b1;
        else               cur_row = row_q;
        blk_log2 = 3'(MOS_MIN_LOG2) + 3'(size);
        col_mask = COL_W'((32'd1 << blk_log2) - 32'd1);
        row_mask = ROW_W'((32'd1 << blk_log2) - 32'd1);
        blk_left = (cur_col & col_mask) == '0;
        blk_top  = (cur_row & row_mask) == '0;
        slot     = SLOT_W'(cur_col >> blk_log2);
    end

    always_comb begin
        if (blk_top) mos_y = blk_left ? in_b.y : hold_q;
        else         mos_y = line_mem[slot];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            row_q  <= '0;
            hold_q <= '0;
        end else if (in_b.vld) begin
            col_q <= cur_col + 1'b1;
            row_q <= cur_row;
            if (blk_top && blk_left) hold_q <= in_b.y;
        end
    end

    // line store: one entry per block of the top line in a block row
    always_ff @(posedge clk) begin
        if (in_b.vld && blk_top && blk_left) line_mem[slot] <= in_b.y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_b <= '0;
        end else begin
            out_b <= '{vld: in_b.vld, sol: in_b.sol, sof: in_b.sof,
                       sepia: in_b.sepia, y: (en ? mos_y : in_b.y)};
        end
    end
endmodule

// File: rtl/luma_tone_fx.sv
module luma_tone_fx
    import luma_fx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  beat_t      in_b,
    input  logic       sol_en,
    input  logic [1:0] sol_depth,
    input  logic       slc_en,
    input  logic       slc_pol,
    input  pix_t       slc_level,
    input  logic       neg,
    input  logic       clear,
    output beat_t      out_b
);
    pix_t v_sol, v_slc, v_neg, v_out;

    always_comb begin
        v_sol = sol_en ? solarize(in_b.y, sol_depth) : in_b.y;
        v_slc = slc_en ? slice_pix(v_sol, slc_level, slc_pol) : v_sol;
        v_neg = neg ? (PIX_MAX - v_slc) : v_slc;
        v_out = clear ? '0 : v_neg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_b <= '0;
        end else begin
            out_b <= '{vld: in_b.vld, sol: in_b.sol, sof: in_b.sof,
                       sepia: in_b.sepia, y: v_out};
        end
    end
endmodule

// File: rtl/luma_fx_top.sv
module luma_fx_top
    import luma_fx_pkg::*;
#(
    parameter int MAX_COLS = 1024,
    parameter int MAX_ROWS = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  logic       in_sol,
    input  logic       in_sof,
    input  logic [7:0] in_y,
    input  logic [5:0] cfg_gain,
    input  logic       cfg_gain_x2,
    input  logic [7:0] cfg_ped,
    input  logic       cfg_mos_en,
    input  logic [1:0] cfg_mos_size,
    input  logic       cfg_sol_en,
    input  logic [1:0] cfg_sol_depth,
    input  logic       cfg_slc_en,
    input  logic       cfg_slc_pol,
    input  logic [7:0] cfg_slc_level,
    input  logic       cfg_neg,
    input  logic       cfg_clear,
    input  logic       cfg_sepia,
    output logic       out_vld,
    output logic       out_sol,
    output logic       out_sof,
    output logic [7:0] out_y,
    output logic       out_sepia
);
    beat_t in_b, lvl_b, mos_b, fx_b;

    // strobes only count together with a valid sample
    assign in_b = '{vld: in_vld, sol: in_sol & in_vld, sof: in_sof & in_vld,
                    sepia: cfg_sepia, y: in_y};

    luma_gain_ped u_level (
        .clk     (clk),
        .rst     (rst),
        .in_b    (in_b),
        .gain    (cfg_gain),
        .gain_x2 (cfg_gain_x2),
        .ped     (cfg_ped),
        .out_b   (lvl_b)
    );

    luma_mosaic #(.MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS)) u_mosaic (
        .clk   (clk),
        .rst   (rst),
        .in_b  (lvl_b),
        .en    (cfg_mos_en),
        .size  (mos_size_e'(cfg_mos_size)),
        .out_b (mos_b)
    );

    luma_tone_fx u_tone (
        .clk       (clk),
        .rst       (rst),
        .in_b      (mos_b),
        .sol_en    (cfg_sol_en),
        .sol_depth (cfg_sol_depth),
        .slc_en    (cfg_slc_en),
        .slc_pol   (cfg_slc_pol),
        .slc_level (cfg_slc_level),
        .neg       (cfg_neg),
        .clear     (cfg_clear),
        .out_b     (fx_b)
    );

    assign out_vld   = fx_b.vld;
    assign out_sol   = fx_b.sol;
    assign out_sof   = fx_b.sof;
    assign out_sepia = fx_b.sepia;
    assign out_y     = fx_b.y;
endmodule

// File: rtl/luma_fx_chk.sv
module luma_fx_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_vld,
    input logic       cfg_sol_en,
    input logic [1:0] cfg_sol_depth,
    input logic       cfg_slc_en,
    input logic       cfg_neg,
    input logic       cfg_clear,
    input logic       cfg_sepia,
    input logic       out_vld,
    input logic       out_sol,
    input logic       out_sof,
    input logic [7:0] out_y,
    input logic       out_sepia
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_vld == $past(in_vld, 3)));

    p_sepia_delay_r11: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_sepia == $past(cfg_sepia, 3)));

    p_strobe_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (!out_sol && !out_sof));

    p_slice_binary_r7: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $past(cfg_slc_en)) |-> (out_y == 8'h00 || out_y == 8'hFF));

    p_clear_blank_r9: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $past(cfg_clear)) |-> (out_y == 8'h00));

    p_solar_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $past(cfg_sol_en) && !$past(cfg_slc_en) && !$past(cfg_neg)
         && !$past(cfg_clear))
        |-> ({1'b0, out_y} < (9'd8 << $past(cfg_sol_depth))));
endmodule

bind luma_fx_top luma_fx_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_vld        (in_vld),
    .cfg_sol_en    (cfg_sol_en),
    .cfg_sol_depth (cfg_sol_depth),
    .cfg_slc_en    (cfg_slc_en),
    .cfg_neg       (cfg_neg),
    .cfg_clear     (cfg_clear),
    .cfg_sepia     (cfg_sepia),
    .out_vld       (out_vld),
    .out_sol       (out_sol),
    .out_sof       (out_sof),
    .out_y         (out_y),
    .out_sepia     (out_sepia)
);

// File: tb/luma_fx_top_tb.sv
`timescale 1ns/1ps
module luma_fx_top_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic       in_vld, in_sol, in_sof;
    logic [7:0] in_y;
    logic [5:0] cfg_gain;
    logic       cfg_gain_x2;
    logic [7:0] cfg_ped;
    logic       cfg_mos_en;
    logic [1:0] cfg_mos_size;
    logic       cfg_sol_en;
    logic [1:0] cfg_sol_depth;
    logic       cfg_slc_en, cfg_slc_pol;
    logic [7:0] cfg_slc_level;
    logic       cfg_neg, cfg_clear, cfg_sepia;
    logic       out_vld, out_sol, out_sof, out_sepia;
    logic [7:0] out_y;

    luma_fx_top dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_sol(in_sol), .in_sof(in_sof),
        .in_y(in_y), .cfg_gain(cfg_gain), .cfg_gain_x2(cfg_gain_x2), .cfg_ped(cfg_ped),
        .cfg_mos_en(cfg_mos_en), .cfg_mos_size(cfg_mos_size), .cfg_sol_en(cfg_sol_en),
        .cfg_sol_depth(cfg_sol_depth), .cfg_slc_en(cfg_slc_en), .cfg_slc_pol(cfg_slc_pol),
        .cfg_slc_level(cfg_slc_level), .cfg_neg(cfg_neg), .cfg_clear(cfg_clear),
        .cfg_sepia(cfg_sepia), .out_vld(out_vld), .out_sol(out_sol), .out_sof(out_sof),
        .out_y(out_y), .out_sepia(out_sepia)
    );

    typedef struct {
        int    due;
        int    y;
        bit    sol;
        bit    sof;
        bit    sep;
        string tag;
    } exp_t;

    exp_t  expq[$];
    int    cyc = 0;
    int    n_tests = 0;
    int    n_fail = 0;
    bit    done = 0;
    int    line_ref [0:255];

    // bench-side copy of the controls
    int m_gain, m_x2, m_ped, m_mos, m_msz, m_sol, m_sdep, m_slc, m_pol, m_lev, m_neg, m_clr, m_sep;
    string cur_tag;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic observe();
        if (expq.size() != 0 && expq[0].due == cyc) begin
            exp_t e;
            e = expq.pop_front();
            check(out_vld === 1'b1, "R11", "valid at latency 3", int'(out_vld), 1);
            check(int'(out_y) == e.y, e.tag, "luma", int'(out_y), e.y);
            check({out_sol, out_sof, out_sepia} === {e.sol, e.sof, e.sep}, "R11",
                  "sol/sof/sepia", int'({out_sol, out_sof, out_sepia}),
                  int'({e.sol, e.sof, e.sep}));
        end else begin
            check(out_vld === 1'b0, "R12", "no output without sample", int'(out_vld), 0);
        end
    endtask

    task automatic step(input bit v, input bit sl, input bit sf, input int y);
        @(negedge clk);
        observe();
        in_vld = v;
        in_sol = sl;
        in_sof = sf;
        in_y   = y[7:0];
    endtask

    task automatic apply_cfg(input string tag);
        cur_tag       = tag;
        cfg_gain      = m_gain[5:0];
        cfg_gain_x2   = m_x2[0];
        cfg_ped       = m_ped[7:0];
        cfg_mos_en    = m_mos[0];
        cfg_mos_size  = m_msz[1:0];
        cfg_sol_en    = m_sol[0];
        cfg_sol_depth = m_sdep[1:0];
        cfg_slc_en    = m_slc[0];
        cfg_slc_pol   = m_pol[0];
        cfg_slc_level = m_lev[7:0];
        cfg_neg       = m_neg[0];
        cfg_clear     = m_clr[0];
        cfg_sepia     = m_sep[0];
    endtask

    task automatic cfg_plain();
        m_gain = 32; m_x2 = 0; m_ped = 0; m_mos = 0; m_msz = 0; m_sol = 0; m_sdep = 0;
        m_slc = 0; m_pol = 0; m_lev = 0; m_neg = 0; m_clr = 0; m_sep = 0;
    endtask

    function automatic int pattern(input int c, input int r, input int seed);
        if (c == 1) return 255;
        if (c == 2) return 0;
        return (c * 37 + r * 11 + seed * 53 + c * r) % 256;
    endfunction

    function automatic int model_level(input int v);
        int t;
        t = (v * m_gain) / 32;
        if (m_x2 != 0) t = t * 2;
        if (t > 255) t = 255;
        t = t + m_ped;
        if (t > 255) t = 255;
        return t;
    endfunction

    function automatic int model_tone(input int v);
        int t;
        t = v;
        if (m_sol != 0) t = t % (8 << m_sdep);
        if (m_slc != 0) t = ((t > m_lev) == (m_pol != 0)) ? 255 : 0;
        if (m_neg != 0) t = 255 - t;
        if (m_clr != 0) t = 0;
        return t;
    endfunction

    task automatic send_frame(input int w, input int h, input int gap, input int seed);
        int hold;
        int n;
        hold = 0;
        n = 4 << m_msz;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                int v;
                int m;
                exp_t e;
                v = pattern(c, r, seed);
                m = model_level(v);
                if (m_mos != 0) begin
                    if (r % n == 0) begin
                        if (c % n == 0) hold = m;
                        line_ref[c] = hold;
                        m = hold;
                    end else begin
                        m = line_ref[c];
                    end
                end
                step(1'b1, c == 0, (c == 0) && (r == 0), v);
                e.due = cyc + 3;
                e.y   = model_tone(m);
                e.sol = (c == 0);
                e.sof = (c == 0) && (r == 0);
                e.sep = (m_sep != 0);
                e.tag = cur_tag;
                expq.push_back(e);
            end
            // idle gap with spurious strobes (R12)
            for (int g = 0; g < gap; g++) step(1'b0, 1'b1, g == 0, (r * 29 + g * 7) % 256);
        end
        for (int d = 0; d < 6; d++) step(1'b0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        rst = 1'b1;
        in_vld = 1'b0; in_sol = 1'b0; in_sof = 1'b0; in_y = '0;
        cfg_plain();
        m_sep = 1;
        apply_cfg("R1");
        in_vld = 1'b1; in_sol = 1'b1; in_sof = 1'b1; in_y = 8'd200;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!out_vld && !out_sol && !out_sof && !out_sepia && out_y == 8'd0,
                  "R1", "outputs in reset",
                  int'({out_vld, out_sol, out_sof, out_sepia, out_y}), 0);
        end
        in_vld = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(!out_vld && out_y == 8'd0, "R1", "first cycle after reset",
              int'({out_vld, out_y}), 0);

        // plain path: unity gain, every effect off
        cfg_plain(); apply_cfg("R10 passthrough");
        send_frame(16, 4, 3, 1);
        // gain variants
        cfg_plain(); m_gain = 16; apply_cfg("R2 half gain");
        send_frame(16, 3, 2, 2);
        cfg_plain(); m_gain = 63; apply_cfg("R2 max gain saturation");
        send_frame(16, 3, 2, 3);
        cfg_plain(); m_gain = 40; m_x2 = 1; m_sep = 1; apply_cfg("R2 extra x2");
        send_frame(16, 3, 1, 4);
        // pedestal
        cfg_plain(); m_ped = 200; apply_cfg("R3 pedestal saturation");
        send_frame(16, 3, 2, 5);
        cfg_plain(); m_gain = 20; m_ped = 37; apply_cfg("R3 pedestal after gain");
        send_frame(16, 3, 2, 6);
        // mosaic, all sizes
        for (int s = 0; s < 4; s++) begin
            cfg_plain(); m_mos = 1; m_msz = s; m_sep = s % 2;
            apply_cfg("R4,R5 mosaic");
            send_frame(64, 64, 4, 7 + s);
        end
        // mosaic restart on a short frame then a new frame
        cfg_plain(); m_mos = 1; m_msz = 1; apply_cfg("R5 frame restart");
        send_frame(24, 5, 2, 11);
        send_frame(24, 10, 2, 12);
        // solarize
        for (int d = 0; d < 4; d++) begin
            cfg_plain(); m_sol = 1; m_sdep = d; apply_cfg("R6 solarize");
            send_frame(16, 3, 1, 13 + d);
        end
        // slice
        cfg_plain(); m_slc = 1; m_pol = 1; m_lev = 100; apply_cfg("R7 slice positive");
        send_frame(16, 3, 1, 17);
        cfg_plain(); m_slc = 1; m_pol = 0; m_lev = 100; apply_cfg("R7 slice negative");
        send_frame(16, 3, 1, 18);
        cfg_plain(); m_slc = 1; m_pol = 1; m_lev = 255; apply_cfg("R7 level 255");
        send_frame(16, 2, 1, 19);
        cfg_plain(); m_slc = 1; m_pol = 1; m_lev = 0; apply_cfg("R7 level 0");
        send_frame(16, 2, 1, 20);
        // inversion
        cfg_plain(); m_neg = 1; apply_cfg("R8 negative");
        send_frame(16, 3, 1, 21);
        // full chain order
        cfg_plain(); m_gain = 48; m_ped = 20; m_mos = 1; m_msz = 1; m_sol = 1; m_sdep = 2;
        m_neg = 1; apply_cfg("R10 chain order");
        send_frame(32, 16, 2, 22);
        cfg_plain(); m_gain = 50; m_sol = 1; m_sdep = 3; m_slc = 1; m_pol = 0; m_lev = 30;
        m_neg = 1; apply_cfg("R10 solarize-slice-invert");
        send_frame(16, 3, 1, 23);
        // clear overrides everything
        cfg_plain(); m_gain = 63; m_x2 = 1; m_ped = 9; m_mos = 1; m_sol = 1; m_slc = 1;
        m_pol = 0; m_neg = 1; m_clr = 1; m_sep = 1; apply_cfg("R9 clear");
        send_frame(16, 4, 1, 24);

        check(expq.size() == 0, "R11", "samples never delivered", expq.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R11 watchdog expired: actual %0d expected %0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule